// File: doc/BRIEF.md
# Shifted Operand Unit with Carry

This unit prepares the second operand of an integer ALU. It takes a 32-bit register value and shifts or rotates it by an amount taken either from a 5-bit immediate field or from a register. Alongside the shifted word it produces the shifter carry-out, which the flag logic uses when the instruction updates the carry flag. Five operations are available: logical left, logical right, arithmetic right, rotate right, and a one-place rotate right through the carry flag.

The immediate field cannot encode a shift of 32, so some zero codes are reused. A logical or arithmetic right shift by an immediate zero means a shift of 32. A rotate by an immediate zero selects the rotate through carry. A register amount is read from its bottom 8 bits, so it can reach 255, and every amount has a defined result. The output is registered. A result and its carry appear one clock after an input is marked valid, and they hold until the next valid input.

Top module: `opnd_shifter`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid`, `sh_result` and `carry_out` are all 0 until the first valid input has been registered.
- R2: `out_valid` rises exactly one clock after each cycle with `in_valid` high and is low otherwise. When `in_valid` is low, `sh_result` and `carry_out` keep their previous values.
- R3: Shift kind code 2'b00 is a logical left shift. For amounts 1 to 31 it fills the vacated low bits with zeros, and the carry is the last bit shifted out, bit (32 - n) of the operand.
- R4: Shift kind code 2'b01 is a logical right shift. For amounts 1 to 31 it fills the vacated high bits with zeros, and the carry is bit (n - 1) of the operand.
- R5: Shift kind code 2'b10 is an arithmetic right shift. For amounts 1 to 31 it fills the vacated high bits with copies of bit 31, and the carry is bit (n - 1).
- R6: Shift kind code 2'b11 is a rotate right. For an amount whose value modulo 32 is m, with m nonzero, bits leaving bit 0 re-enter at bit 31, and the carry is bit (m - 1) of the operand.
- R7: An effective amount of 0 passes the operand unchanged and passes `carry_in` through to the carry. This covers a left shift with immediate 0, and any kind with a register amount whose bottom 8 bits are 0.
- R8: With `use_reg_amt` = 0 and an immediate of 0, a logical right shift acts as a shift by 32: the result is 0 and the carry is bit 31. An arithmetic right shift acts the same way: every bit becomes bit 31, and the carry is bit 31.
- R9: With `use_reg_amt` = 0, kind 2'b11 and an immediate of 0, the operation is a rotate through carry. The result is {`carry_in`, operand[31:1]} and the carry is operand bit 0.
- R10: With `use_reg_amt` = 1, only `reg_amt[7:0]` sets the amount. Bits 31:8 have no effect on the result or the carry.
- R11: A register amount of exactly 32 on a logical shift gives 0. The carry is bit 0 for a left shift and bit 31 for a right shift. A register amount of 33 to 255 on a logical shift gives 0 with carry 0.
- R12: A register amount of 32 or more on an arithmetic right shift fills the word with bit 31, and the carry equals bit 31.
- R13: A nonzero register amount that is a multiple of 32, on a rotate, returns the operand unchanged with the carry equal to bit 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | The operand and controls are valid this cycle |
| src_val | input | 32 | Operand to shift |
| sh_kind | input | 2 | 00 left logical, 01 right logical, 10 right arithmetic, 11 rotate right |
| use_reg_amt | input | 1 | 1: amount from `reg_amt`, 0: amount from `imm_amt` |
| imm_amt | input | 5 | Immediate shift amount |
| reg_amt | input | 32 | Register holding the amount (bits 7:0 used) |
| carry_in | input | 1 | Current carry flag |
| out_valid | output | 1 | `sh_result` and `carry_out` were updated at the last edge |
| sh_result | output | 32 | Shifted operand |
| carry_out | output | 1 | Shifter carry-out |

## Verification
Several behaviours are checked by assertions on every cycle:
- the one-cycle valid timing and the hold of the outputs when no input is valid;
- the pass-through of the operand and carry on a zero amount;
- the immediate-zero encodings for a shift of 32 and for the rotate through carry;
- the sign fill of large arithmetic shifts;
- the identity result of rotates by a multiple of 32.

The bit-exact values for ordinary amounts, and the carry taken from the last bit shifted out, are shown only by the bench's scenarios. The same applies to the zero results of large logical shifts and to the masking of the upper register bits. These scenarios are compared each clock against an arithmetic model built from wide shifts.

// File: rtl/opnd_shifter_pkg.sv
package opnd_shifter_pkg;

  typedef enum logic [1:0] {
    SK_LSL = 2'b00,
    SK_LSR = 2'b01,
    SK_ASR = 2'b10,
    SK_ROR = 2'b11
  } sh_kind_e;

  typedef enum logic [2:0] {
    NOP_PASS = 3'd0,
    NOP_LSL  = 3'd1,
    NOP_LSR  = 3'd2,
    NOP_ASR  = 3'd3,
    NOP_ROR  = 3'd4,
    NOP_RRX  = 3'd5
  } norm_op_e;

endpackage

// File: rtl/opnd_amt_decode.sv
module opnd_amt_decode
  import opnd_shifter_pkg::*;
#(
  parameter int W        = 32,
  parameter int IMM_BITS = 5,
  parameter int REG_BITS = 8,
  parameter int CNT_W    = 8
) (
  input  sh_kind_e             kind,
  input  logic                 use_reg,
  input  logic [IMM_BITS-1:0]  imm_amt,
  input  logic [REG_BITS-1:0]  reg_low,
  output norm_op_e             op,
  output logic [CNT_W-1:0]     cnt
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(W);

  // Normalise both amount sources into one operation and a plain count.
  always_comb begin
    op  = NOP_PASS;
    cnt = '0;
    if (use_reg) begin
      cnt = CNT_W'(reg_low);
      if (reg_low != '0) begin
        unique case (kind)
          SK_LSL:  op = NOP_LSL;
          SK_LSR:  op = NOP_LSR;
          SK_ASR:  op = NOP_ASR;
          default: op = NOP_ROR;
        endcase
      end
    end else begin
      cnt = CNT_W'(imm_amt);
      unique case (kind)
        SK_LSL: op = (imm_amt == '0) ? NOP_PASS : NOP_LSL;
        SK_LSR: begin
          op = NOP_LSR;
          if (imm_amt == '0) cnt = FULL_CNT;
        end
        SK_ASR: begin
          op = NOP_ASR;
          if (imm_amt == '0) cnt = FULL_CNT;
        end
        default: op = (imm_amt == '0) ? NOP_RRX : NOP_ROR;
      endcase
    end
  end

endmodule

// File: rtl/opnd_shift_core.sv
module opnd_shift_core
  import opnd_shifter_pkg::*;
#(
  parameter int W     = 32,
  parameter int CNT_W = 8
) (
  input  norm_op_e          op,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [W-1:0]      x,
  input  logic              cin,
  output logic [W-1:0]      res,
  output logic              cout
);

  localparam int LOG_W = $clog2(W);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(W);

  // Each function returns {carry, word}.
  function automatic logic [W:0] f_lsl(input logic [W-1:0] v, input logic [CNT_W-1:0] n);
    logic [W-1:0] t;
    if (n < FULL_CNT) begin
      t = v >> (FULL_CNT - n);
      return {t[0], v << n};
    end else if (n == FULL_CNT) begin
      return {v[0], {W{1'b0}}};
    end
    return '0;
  endfunction

  function automatic logic [W:0] f_lsr(input logic [W-1:0] v, input logic [CNT_W-1:0] n);
    logic [W-1:0] t;
    if (n < FULL_CNT) begin
      t = v >> (n - 1'b1);
      return {t[0], v >> n};
    end else if (n == FULL_CNT) begin
      return {v[W-1], {W{1'b0}}};
    end
    return '0;
  endfunction

  function automatic logic [W:0] f_asr(input logic [W-1:0] v, input logic [CNT_W-1:0] n);
    logic [W-1:0] t;
    logic [W-1:0] s;
    if (n < FULL_CNT) begin
      t = v >> (n - 1'b1);
      s = $signed(v) >>> n;
      return {t[0], s};
    end
    return {v[W-1], {W{v[W-1]}}};
  endfunction

  function automatic logic [W:0] f_ror(input logic [W-1:0] v, input logic [CNT_W-1:0] n);
    logic [LOG_W-1:0] m;
    logic [W-1:0]     r;
    m = n[LOG_W-1:0];
    if (m == '0) return {v[W-1], v};
    r = (v >> m) | (v << (W - int'(m)));
    return {r[W-1], r};
  endfunction

  function automatic logic [W:0] f_rrx(input logic [W-1:0] v, input logic c);
    return {v[0], c, v[W-1:1]};
  endfunction

  always_comb begin
    unique case (op)
      NOP_LSL: {cout, res} = f_lsl(x, cnt);
      NOP_LSR: {cout, res} = f_lsr(x, cnt);
      NOP_ASR: {cout, res} = f_asr(x, cnt);
      NOP_ROR: {cout, res} = f_ror(x, cnt);
      NOP_RRX: {cout, res} = f_rrx(x, cin);
      default: {cout, res} = {cin, x};
    endcase
  end

endmodule

// File: rtl/opnd_shifter.sv
module opnd_shifter
  import opnd_shifter_pkg::*;
#(
  parameter int W        = 32,
  parameter int IMM_BITS = 5,
  parameter int REG_BITS = 8,
  parameter int REG_W    = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [W-1:0]        src_val,
  input  logic [1:0]          sh_kind,
  input  logic                use_reg_amt,
  input  logic [IMM_BITS-1:0] imm_amt,
  input  logic [REG_W-1:0]    reg_amt,
  input  logic                carry_in,
  output logic                out_valid,
  output logic [W-1:0]        sh_result,
  output logic                carry_out
);

  localparam int CNT_W = (REG_BITS > IMM_BITS + 1) ? REG_BITS : IMM_BITS + 1;

  // Named internal events, visible to the bound checker.
  norm_op_e          dec_op;
  logic [CNT_W-1:0]  dec_cnt;
  logic [W-1:0]      comb_res;
  logic              comb_c;
  logic              unused_amt_hi;

  assign unused_amt_hi = ^reg_amt[REG_W-1:REG_BITS];

  opnd_amt_decode #(
    .W(W), .IMM_BITS(IMM_BITS), .REG_BITS(REG_BITS), .CNT_W(CNT_W)
  ) u_dec (
    .kind    (sh_kind_e'(sh_kind)),
    .use_reg (use_reg_amt),
    .imm_amt (imm_amt),
    .reg_low (reg_amt[REG_BITS-1:0]),
    .op      (dec_op),
    .cnt     (dec_cnt)
  );

  opnd_shift_core #(.W(W), .CNT_W(CNT_W)) u_core (
    .op   (dec_op),
    .cnt  (dec_cnt),
    .x    (src_val),
    .cin  (carry_in),
    .res  (comb_res),
    .cout (comb_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      sh_result <= '0;
      carry_out <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        sh_result <= comb_res;
        carry_out <= comb_c;
      end
    end
  end

endmodule

// File: rtl/opnd_shifter_chk.sv
module opnd_shifter_chk
  import opnd_shifter_pkg::*;
#(
  parameter int W        = 32,
  parameter int IMM_BITS = 5,
  parameter int REG_BITS = 8,
  parameter int REG_W    = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic [W-1:0]        src_val,
  input logic [1:0]          sh_kind,
  input logic                use_reg_amt,
  input logic [IMM_BITS-1:0] imm_amt,
  input logic [REG_W-1:0]    reg_amt,
  input logic                carry_in,
  input logic                out_valid,
  input logic [W-1:0]        sh_result,
  input logic                carry_out,
  input norm_op_e            dec_op
);

  localparam int LOG_W = $clog2(W);
  localparam logic [REG_BITS-1:0] W_REG = REG_BITS'(W);

  logic [REG_BITS-1:0] low_amt;
  assign low_amt = reg_amt[REG_BITS-1:0];

  a_r2_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r2_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(sh_result) && $stable(carry_out)));

  a_r7_zero_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dec_op == NOP_PASS) |=>
      (sh_result == $past(src_val) && carry_out == $past(carry_in)));

  a_r8_imm_lsr32: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !use_reg_amt && sh_kind == 2'b01 && imm_amt == '0) |=>
      (sh_result == '0 && carry_out == $past(src_val[W-1])));

  a_r9_rrx: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !use_reg_amt && sh_kind == 2'b11 && imm_amt == '0) |=>
      (sh_result == {$past(carry_in), $past(src_val[W-1:1])} &&
       carry_out == $past(src_val[0])));

  a_r12_asr_big: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && use_reg_amt && sh_kind == 2'b10 && low_amt >= W_REG) |=>
      (sh_result == {W{$past(src_val[W-1])}} && carry_out == $past(src_val[W-1])));

  a_r13_ror_mult: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && use_reg_amt && sh_kind == 2'b11 && low_amt != '0 &&
     low_amt[LOG_W-1:0] == '0) |=>
      (sh_result == $past(src_val) && carry_out == $past(src_val[W-1])));

endmodule

bind opnd_shifter opnd_shifter_chk #(
  .W(W), .IMM_BITS(IMM_BITS), .REG_BITS(REG_BITS), .REG_W(REG_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .src_val     (src_val),
  .sh_kind     (sh_kind),
  .use_reg_amt (use_reg_amt),
  .imm_amt     (imm_amt),
  .reg_amt     (reg_amt),
  .carry_in    (carry_in),
  .out_valid   (out_valid),
  .sh_result   (sh_result),
  .carry_out   (carry_out),
  .dec_op      (dec_op)
);

// File: tb/tb_opnd_shifter.sv
module tb_opnd_shifter;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] src_val = '0;
  logic [1:0]  sh_kind = '0;
  logic        use_reg_amt = 1'b0;
  logic [4:0]  imm_amt = '0;
  logic [31:0] reg_amt = '0;
  logic        carry_in = 1'b0;
  logic        out_valid;
  logic [31:0] sh_result;
  logic        carry_out;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // Expected output after the next clock edge.
  logic        exp_v = 1'b0;
  logic [31:0] exp_r = '0;
  logic        exp_c = 1'b0;
  string       exp_tag = "R1";

  always #4 clk = ~clk;

  opnd_shifter dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_val(src_val),
    .sh_kind(sh_kind), .use_reg_amt(use_reg_amt), .imm_amt(imm_amt),
    .reg_amt(reg_amt), .carry_in(carry_in), .out_valid(out_valid),
    .sh_result(sh_result), .carry_out(carry_out)
  );

  // Arithmetic reference built on 64-bit shifts; returns {carry, word}.
  function automatic logic [32:0] model(input logic [1:0] k, input logic sel,
                                        input logic [4:0] imm, input logic [31:0] rv,
                                        input logic [31:0] x, input logic c);
    int n;
    logic [63:0] wide;
    logic signed [63:0] sw;
    n = sel ? int'(rv[7:0]) : int'(imm);
    if (n == 0) begin
      if (sel || k == 2'b00) return {c, x};
      if (k == 2'b11) return {x[0], c, x[31:1]};
      n = 32;
    end
    case (k)
      2'b00: begin
        if (n > 32) return '0;
        wide = {32'b0, x} << n;
        return {wide[32], wide[31:0]};
      end
      2'b01: begin
        if (n > 32) return '0;
        wide = {x, 32'b0} >> n;
        return {wide[31], wide[63:32]};
      end
      2'b10: begin
        if (n > 32) n = 32;
        sw = $signed({x, 32'b0}) >>> n;
        return {sw[31], sw[63:32]};
      end
      default: begin
        wide = {x, x} >> (n % 32);
        return {wide[31], wide[31:0]};
      end
    endcase
  endfunction

  task automatic compare();
    checks++;
    if (out_valid !== exp_v || sh_result !== exp_r || carry_out !== exp_c) begin
      errors++;
      $display("FAIL %s: got v=%0b r=%08h c=%0b, expected v=%0b r=%08h c=%0b",
               exp_tag, out_valid, sh_result, carry_out, exp_v, exp_r, exp_c);
    end
  endtask

  task automatic step(input logic v, input logic [1:0] k, input logic sel,
                      input logic [4:0] imm, input logic [31:0] rv,
                      input logic [31:0] x, input logic c, input string tag);
    logic [32:0] m;
    @(negedge clk);
    compare();
    in_valid = v; sh_kind = k; use_reg_amt = sel; imm_amt = imm;
    reg_amt = rv; src_val = x; carry_in = c;
    exp_v = v;
    exp_tag = tag;
    if (v) begin
      m = model(k, sel, imm, rv, x, c);
      exp_c = m[32];
      exp_r = m[31:0];
    end
  endtask

  function automatic string classify(input logic [1:0] k, input logic sel,
                                     input logic [4:0] imm, input logic [31:0] rv);
    int n;
    n = sel ? int'(rv[7:0]) : int'(imm);
    if (n == 0 && (sel || k == 2'b00)) return "R7";
    if (!sel && n == 0) return (k == 2'b11) ? "R9" : "R8";
    if (sel && n >= 32 && k != 2'b11) return (k == 2'b10) ? "R12" : "R11";
    if (sel && k == 2'b11 && n % 32 == 0) return "R13";
    if (sel && rv[31:8] != 0) return "R10";
    case (k)
      2'b00:   return "R3";
      2'b01:   return "R4";
      2'b10:   return "R5";
      default: return "R6";
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || sh_result !== '0 || carry_out !== 1'b0) begin
      errors++;
      $display("FAIL R1: got v=%0b r=%08h c=%0b during reset, expected 0/0/0",
               out_valid, sh_result, carry_out);
    end
    rst_n = 1'b1;
    // R1: first compare inside step sees the post-reset state
    step(1, 2'b00, 0, 5'd4,  32'h0, 32'h8000_000F, 0, "R3");
    step(1, 2'b00, 0, 5'd31, 32'h0, 32'h0000_0003, 0, "R3");
    step(1, 2'b01, 0, 5'd1,  32'h0, 32'h0000_0001, 0, "R4");
    step(1, 2'b01, 1, 5'd0,  32'd31, 32'hC000_0000, 0, "R4");
    step(1, 2'b10, 0, 5'd8,  32'h0, 32'h8765_4321, 0, "R5");
    step(1, 2'b10, 0, 5'd3,  32'h0, 32'h7000_0004, 1, "R5");
    step(1, 2'b11, 0, 5'd4,  32'h0, 32'h1234_5678, 0, "R6");
    step(1, 2'b11, 1, 5'd0,  32'd37, 32'hF000_0010, 0, "R6");
    step(1, 2'b00, 0, 5'd0,  32'h0, 32'hDEAD_BEEF, 1, "R7");
    step(1, 2'b10, 1, 5'd9,  32'hFFFF_FF00, 32'h8000_0001, 1, "R7");
    step(1, 2'b01, 0, 5'd0,  32'h0, 32'h8000_0000, 0, "R8");
    step(1, 2'b10, 0, 5'd0,  32'h0, 32'h8000_0000, 0, "R8");
    step(1, 2'b10, 0, 5'd0,  32'h0, 32'h7FFF_FFFF, 1, "R8");
    step(1, 2'b11, 0, 5'd0,  32'h0, 32'h0000_0003, 1, "R9");
    step(1, 2'b11, 0, 5'd0,  32'h0, 32'hFFFF_FFFE, 0, "R9");
    step(1, 2'b01, 1, 5'd0,  32'hABCD_0104, 32'hF0F0_F0F0, 0, "R10");
    step(1, 2'b00, 1, 5'd0,  32'h0000_0100, 32'h1234_5678, 1, "R10");
    step(1, 2'b00, 1, 5'd0,  32'd32, 32'h0000_0001, 0, "R11");
    step(1, 2'b01, 1, 5'd0,  32'd32, 32'h8000_0000, 0, "R11");
    step(1, 2'b00, 1, 5'd0,  32'd33, 32'hFFFF_FFFF, 1, "R11");
    step(1, 2'b01, 1, 5'd0,  32'd255, 32'hFFFF_FFFF, 1, "R11");
    step(1, 2'b10, 1, 5'd0,  32'd32, 32'h8000_0000, 0, "R12");
    step(1, 2'b10, 1, 5'd0,  32'd200, 32'h4000_0000, 1, "R12");
    step(1, 2'b11, 1, 5'd0,  32'd32, 32'h8000_1234, 0, "R13");
    step(1, 2'b11, 1, 5'd0,  32'd224, 32'h0000_1234, 1, "R13");
    step(0, 2'b00, 0, 5'd1,  32'h0, 32'hFFFF_FFFF, 0, "R2");
    step(0, 2'b01, 1, 5'd2,  32'h5, 32'h1111_1111, 1, "R2");
    step(1, 2'b00, 0, 5'd1,  32'h0, 32'h4000_0000, 0, "R2");
    for (int i = 0; i < 400; i++) begin
      logic [1:0]  k;
      logic        sel;
      logic [4:0]  imm;
      logic [31:0] rv;
      logic        v;
      k   = 2'($urandom);
      sel = 1'($urandom);
      imm = 5'($urandom);
      rv  = $urandom;
      if ($urandom % 2 == 0) rv[7:0] = 8'($urandom % 70);
      if ($urandom % 3 == 0) rv[31:8] = '0;
      v = ($urandom % 6) != 0;
      step(v, k, sel, imm, rv, $urandom, 1'($urandom),
           v ? classify(k, sel, imm, rv) : "R2");
    end
    step(0, 2'b00, 0, 5'd0, 32'h0, 32'h0, 0, "R2");
    step(0, 2'b00, 0, 5'd0, 32'h0, 32'h0, 0, "R2");
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: got no completion, expected end of run");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule